// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Control

This block supplies the hardware handshake for one serial channel. On the transmit side, it turns the clear-to-send input into a permit that the character shifter consults before it starts each new character. On the receive side, it drives request-to-send from the current receive FIFO occupancy, so that the far end is told to pause before the FIFO overflows.

The transmit gate and the receive throttle have separate enable bits and can be used alone or together. The receive throttle uses two programmable levels, each given in steps of four FIFO entries. Reaching the upper level withdraws RTS. RTS returns only once the occupancy has drained to the lower level. When the throttle is off, RTS is driven from a software modem-control bit. Both handshake lines are active low. The incoming CTS is asynchronous, so it passes through a synchronizer before it is used.

Top module: `auto_flow_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block drives `rts_n` to 1 (inactive) and `tx_permit` to 0. The synchronizer and the receive throttle state also return to their inactive values.
- R2: With `auto_cts_en` = 1, at a rising edge where `char_boundary` = 1, `tx_permit` takes the value 1 if CTS is active (`cts_n` low) and 0 otherwise. CTS is seen through two synchronizer flops, so a level on `cts_n` first affects `tx_permit` at the third rising edge after it is applied.
- R3: With `auto_cts_en` = 0, `tx_permit` is 1 after every rising edge, whatever the state of `cts_n`.
- R4: With `auto_cts_en` = 1, at a rising edge where `char_boundary` = 0, `tx_permit` keeps its value. A character already under way is therefore finished even if CTS is withdrawn.
- R5: With `auto_rts_en` = 1, when `rx_count` ≥ 4 × `halt_lvl` at a rising edge, `rts_n` is 1 after that edge.
- R6: With `auto_rts_en` = 1, when `rx_count` < 4 × `halt_lvl` and `rx_count` ≤ 4 × `resume_lvl` at a rising edge, `rts_n` is 0 after that edge.
- R7: With `auto_rts_en` = 1, when 4 × `resume_lvl` < `rx_count` < 4 × `halt_lvl`, the throttle keeps its previous halted or running state. This state is updated on every edge, including edges where `auto_rts_en` = 0.
- R8: With `auto_rts_en` = 0, `rts_n` equals the inverse of `rts_sw` sampled at the previous rising edge.
- R9: When both the halt condition and the resume condition are met, halt takes priority and `rts_n` is 1. For example, `halt_lvl` = 0 keeps RTS withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_cts_en | input | 1 | Enables gating of the transmitter by CTS |
| auto_rts_en | input | 1 | Enables driving RTS from receive FIFO occupancy |
| rts_sw | input | 1 | Software RTS request, used when `auto_rts_en` = 0 (1 = assert) |
| cts_n | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| char_boundary | input | 1 | High when the transmitter may begin a new character |
| rx_count | input | 7 | Receive FIFO occupancy, 0 to 64 |
| halt_lvl | input | 4 | Halt level, in units of 4 entries |
| resume_lvl | input | 4 | Resume level, in units of 4 entries |
| rts_n | output | 1 | Request-to-send, active low |
| tx_permit | output | 1 | Transmitter may start a character |

## Verification
The bench targets the occupancy band between the two levels.
- A design without hysteresis would toggle RTS there.
- A design that froze its state while the throttle was off would resume with a stale decision.

The bench also sets levels where resume is at or above halt, and sets the halt level to zero. A design without halt priority would then assert RTS into a full FIFO.

On the transmit side, the bench withdraws CTS while no character boundary is present. A design that ignored the boundary would cut a character in half. The bench also measures the latency from a change on `cts_n` to `tx_permit`, which exposes a missing or extra synchronizer stage.

// File: rtl/auto_flow_pkg.sv
// Shared definitions for the automatic flow control block.
// Assumes nothing beyond a standard SystemVerilog package scope.
package auto_flow_pkg;
    // State of the receive throttle: running asserts RTS, halted withdraws it
    typedef enum logic {
        THR_RUN    = 1'b0,
        THR_HALTED = 1'b1
    } thr_state_e;

    // Inactive level of an active-low handshake line
    localparam logic HS_INACTIVE = 1'b1;
endpackage

// File: rtl/afc_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level (a handshake line), not a pulse.
module afc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_chain
            // Shift the level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/afc_tx_gate.sv
// Transmit permit: follows the synchronized CTS only at character
// boundaries when gating is on, and is always open otherwise.
// Assumes char_boundary is high whenever the shifter is idle.
module afc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic cts_active,
    input  logic char_boundary,
    output logic permit
);
    // Register the permit, changing it only where a character may start
    always_ff @(posedge clk) begin
        if (!rst_n)             permit <= 1'b0;
        else if (!gate_en)      permit <= 1'b1;
        else if (char_boundary) permit <= cts_active;
    end
endmodule

// File: rtl/afc_rts_hyst.sv
// Receive throttle with hysteresis between a halt and a resume level.
// Levels are given in units of SCALE entries; halt wins when both match.
// Assumes count never exceeds the FIFO depth.
module afc_rts_hyst
    import auto_flow_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int LVL_W = 4,
    parameter int SCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output thr_state_e       state_next
);
    localparam int SC_W  = (SCALE > 1) ? $clog2(SCALE + 1) : 1;
    localparam int TH_W  = LVL_W + SC_W;
    localparam int CMP_W = (TH_W > CNT_W) ? TH_W : CNT_W;

    thr_state_e       state_q;
    logic [CMP_W-1:0] halt_th;
    logic [CMP_W-1:0] resume_th;
    logic [CMP_W-1:0] cnt_ext;

    // Scale the level fields into entry counts
    always_comb begin
        halt_th   = CMP_W'(halt_lvl)   * CMP_W'(SCALE);
        resume_th = CMP_W'(resume_lvl) * CMP_W'(SCALE);
        cnt_ext   = CMP_W'(count);
    end

    // Next throttle state: halt first, then resume, else hold
    always_comb begin
        if (cnt_ext >= halt_th)        state_next = THR_HALTED;
        else if (cnt_ext <= resume_th) state_next = THR_RUN;
        else                           state_next = state_q;
    end

    // Keep the throttle state, tracking even while auto mode is off
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= THR_HALTED;
        else        state_q <= state_next;
    end
endmodule

// File: rtl/auto_flow_ctrl.sv
// Automatic RTS/CTS flow control for one serial channel.
// Gates the transmitter on CTS and drives RTS from receive occupancy.
// Assumes cts_n is asynchronous and all other inputs are synchronous to clk.
module auto_flow_ctrl
    import auto_flow_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int LVL_W       = 4,
    parameter int LVL_SCALE   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_cts_en,
    input  logic             auto_rts_en,
    input  logic             rts_sw,
    input  logic             cts_n,
    input  logic             char_boundary,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [LVL_W-1:0] halt_lvl,
    input  logic [LVL_W-1:0] resume_lvl,
    output logic             rts_n,
    output logic             tx_permit
);
    logic       cts_n_sync;
    thr_state_e thr_next;

    afc_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (HS_INACTIVE)
    ) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_n),
        .q     (cts_n_sync)
    );

    afc_tx_gate u_tx_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .gate_en       (auto_cts_en),
        .cts_active    (~cts_n_sync),
        .char_boundary (char_boundary),
        .permit        (tx_permit)
    );

    afc_rts_hyst #(
        .CNT_W (CNT_W),
        .LVL_W (LVL_W),
        .SCALE (LVL_SCALE)
    ) u_rts_hyst (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (rx_count),
        .halt_lvl   (halt_lvl),
        .resume_lvl (resume_lvl),
        .state_next (thr_next)
    );

    // Register RTS from the throttle or from the software bit
    always_ff @(posedge clk) begin
        if (!rst_n)           rts_n <= HS_INACTIVE;
        else if (auto_rts_en) rts_n <= (thr_next == THR_HALTED);
        else                  rts_n <= ~rts_sw;
    end
endmodule

// File: rtl/auto_flow_ctrl_chk.sv
// Property checker for auto_flow_ctrl, attached by bind below.
// Assumes the default level scaling of the top it is bound to.
module auto_flow_ctrl_chk #(
    parameter int CNT_W     = 7,
    parameter int LVL_W     = 4,
    parameter int LVL_SCALE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_cts_en,
    input logic             auto_rts_en,
    input logic             rts_sw,
    input logic             cts_n,
    input logic             char_boundary,
    input logic [CNT_W-1:0] rx_count,
    input logic [LVL_W-1:0] halt_lvl,
    input logic [LVL_W-1:0] resume_lvl,
    input logic             rts_n,
    input logic             tx_permit
);
    logic [15:0] h_th;
    logic [15:0] r_th;
    logic [15:0] c_ext;

    // Thresholds in entries, for the properties
    always_comb begin
        h_th  = 16'(halt_lvl)   * 16'(LVL_SCALE);
        r_th  = 16'(resume_lvl) * 16'(LVL_SCALE);
        c_ext = 16'(rx_count);
    end

    p_rts_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && c_ext >= h_th) |=> rts_n);

    p_rts_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && c_ext < h_th && c_ext <= r_th) |=> !rts_n);

    p_rts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && $past(auto_rts_en) && c_ext < h_th && c_ext > r_th)
        |=> $stable(rts_n));

    p_rts_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(rts_sw)));

    p_permit_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |=> tx_permit);

    p_permit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && !char_boundary) |=> $stable(tx_permit));

    p_cts_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_permit) && $past(auto_cts_en)) |-> !$past(cts_n, 3));
endmodule

bind auto_flow_ctrl auto_flow_ctrl_chk #(
    .CNT_W     (CNT_W),
    .LVL_W     (LVL_W),
    .LVL_SCALE (LVL_SCALE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_cts_en   (auto_cts_en),
    .auto_rts_en   (auto_rts_en),
    .rts_sw        (rts_sw),
    .cts_n         (cts_n),
    .char_boundary (char_boundary),
    .rx_count      (rx_count),
    .halt_lvl      (halt_lvl),
    .resume_lvl    (resume_lvl),
    .rts_n         (rts_n),
    .tx_permit     (tx_permit)
);

// File: tb/auto_flow_ctrl_bench.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared against a behavioural model written from the requirements.
module auto_flow_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_cts_en, auto_rts_en, rts_sw, cts_n, char_boundary;
    logic [6:0] rx_count;
    logic [3:0] halt_lvl, resume_lvl;
    logic       rts_n, tx_permit;

    int checks = 0;
    int errors = 0;

    // Model state
    logic  m_s1, m_s2, m_tx, m_halt, m_rts;
    string tx_tag, rts_tag;

    always #4 clk = ~clk;

    auto_flow_ctrl u_auto_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en),
        .auto_rts_en(auto_rts_en), .rts_sw(rts_sw), .cts_n(cts_n),
        .char_boundary(char_boundary), .rx_count(rx_count),
        .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
        .rts_n(rts_n), .tx_permit(tx_permit)
    );

    function automatic logic model_halt(input logic prev, input int cnt,
                                        input int hl, input int rl);
        if (cnt >= hl * 4)      return 1'b1;
        else if (cnt <= rl * 4) return 1'b0;
        else                    return prev;
    endfunction

    function automatic string rts_req(input int cnt, input int hl, input int rl);
        if (cnt >= hl * 4)      return (cnt <= rl * 4) ? "R9" : "R5";
        else if (cnt <= rl * 4) return "R6";
        else                    return "R7";
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One cycle: check outputs from the last edge, drive new inputs, advance model
    task automatic step(input logic rst, input logic ac, input logic ar,
                        input logic sw, input logic cn, input logic bd,
                        input int cnt, input int hl, input int rl);
        @(negedge clk);
        check(tx_tag, "tx_permit", tx_permit, m_tx);
        check(rts_tag, "rts_n", rts_n, m_rts);
        rst_n = rst; auto_cts_en = ac; auto_rts_en = ar; rts_sw = sw;
        cts_n = cn; char_boundary = bd; rx_count = 7'(cnt);
        halt_lvl = 4'(hl); resume_lvl = 4'(rl);
        if (!rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1; m_tx = 1'b0; m_halt = 1'b1; m_rts = 1'b1;
            tx_tag = "R1"; rts_tag = "R1";
        end else begin
            if (!ac) begin m_tx = 1'b1; tx_tag = "R3"; end
            else if (bd) begin m_tx = ~m_s2; tx_tag = "R2"; end
            else tx_tag = "R4";
            m_s2 = m_s1; m_s1 = cn;
            rts_tag = rts_req(cnt, hl, rl);
            m_halt = model_halt(m_halt, cnt, hl, rl);
            if (ar) m_rts = m_halt;
            else begin m_rts = ~sw; rts_tag = "R8"; end
        end
    endtask

    // Watchdog: a hung run is a failure but still reports
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ac, ar, sw, cn, bd;
        int   cnt, hl, rl;
        m_s1 = 1'b1; m_s2 = 1'b1; m_tx = 1'b0; m_halt = 1'b1; m_rts = 1'b1;
        tx_tag = "R1"; rts_tag = "R1";
        rst_n = 1'b0; auto_cts_en = 1'b1; auto_rts_en = 1'b1; rts_sw = 1'b0;
        cts_n = 1'b0; char_boundary = 1'b1; rx_count = '0;
        halt_lvl = 4'd8; resume_lvl = 4'd4;
        // R1: reset state held over several edges
        repeat (3) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 8, 4);

        // R5/R6/R7: climb through the band, halt, drain through the band, resume
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 20, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 31, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 25, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 17, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16, 8, 4);
        // R2: CTS withdrawn; permit falls on the third edge
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10, 8, 4);
        // R4: CTS back, no boundary: permit stays low until one comes
        repeat (5) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10, 8, 4);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 10, 8, 4);
        // R4: CTS withdrawn mid-character: permit held
        repeat (5) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10, 8, 4);
        // R3: gating off opens permit despite CTS inactive
        repeat (2) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10, 8, 4);
        // R9: resume above halt, and halt level zero
        repeat (2) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 10, 2, 5);
        repeat (2) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 0);
        // R8: software RTS, while the hidden throttle keeps tracking (R7)
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 40, 8, 4);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 20, 8, 4);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20, 8, 4);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 20, 8, 4);

        // Seeded random stimulus
        void'($urandom(32'd1234));
        ac = 1'b1; ar = 1'b1; sw = 1'b0; cn = 1'b0; cnt = 0; hl = 8; rl = 4;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 49) == 0) ac = ~ac;
            if ($urandom_range(0, 49) == 0) ar = ~ar;
            if ($urandom_range(0, 9) == 0)  sw = ~sw;
            if ($urandom_range(0, 7) == 0)  cn = ~cn;
            if ($urandom_range(0, 199) == 0) begin
                hl = $urandom_range(0, 15);
                rl = $urandom_range(0, 15);
            end
            if ($urandom_range(0, 19) == 0) cnt = $urandom_range(0, 64);
            else begin
                cnt = cnt + $urandom_range(0, 4) - 2;
                if (cnt < 0)  cnt = 0;
                if (cnt > 64) cnt = 64;
            end
            bd = ($urandom_range(0, 2) == 0);
            step(($urandom_range(0, 999) != 0), ac, ar, sw, cn, bd, cnt, hl, rl);
        end
        step(1'b1, ac, ar, sw, cn, 1'b1, cnt, hl, rl);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule